// File: doc/BRIEF.md
# Operand Extension Length Parser

This block sits behind the opcode decoder of a variable-length instruction front end. Once an instruction has been identified, the decoder gives it the 5-bit addressing-mode field of up to two general operands (A and B), a size code for each, a flag saying whether the operand may be an immediate, and a flag saying whether the operand exists at all. The block then takes the bytes that follow the basic instruction, one per cycle, through a valid/ready handshake.

It locates every extension field without computing any value. Scaled-index bytes come first, then the displacements and immediates of A, then those of B. The length of each displacement is read from its own first byte. When the last field is taken, the block raises a one-cycle done pulse and reports several results: the total extension length, the byte offset of each index byte and each field, the index register named by each index byte, and the number of fields per operand. It also flags reserved, illegal-immediate and nested-index use, so that the pipeline can fault the instruction and advance its fetch pointer by the reported length.

Top module: `ope_ext_parser`

## Requirements
- R1: Modes 0x00 to 0x07 (register) and 0x17 (top of stack) take no extension bytes and report zero fields.
- R2: Modes 0x08 to 0x0F, 0x15 and 0x18 to 0x1B take exactly one displacement.
- R3: Modes 0x10 to 0x12 and 0x16 take two displacements, one after the other. The field count for the operand is 2, and the second field starts where the first one ends.
- R4: The length of a displacement comes from its first byte: 1 byte if bit 7 is 0, 2 bytes if bits 7:6 are 10, and 4 bytes if they are 11.
- R5: Mode 0x14 (immediate) takes 1, 2, 4 or 8 bytes for size codes 0, 1, 2 and 3. The contents of these bytes have no effect on the length.
- R6: Mode 0x14 on an operand whose no-immediate flag is set raises err_imm and takes no bytes.
- R7: Mode 0x13 raises err_reserved and takes no bytes.
- R8: A mode in 0x1C to 0x1F takes one index byte. Index bytes come before all other fields, A's first and then B's. Bits 2:0 of an index byte are reported as the index register, and bits 7:3 are decoded as the operand's base mode.
- R9: A base mode that is itself a scaled-index mode raises err_nested, and the operand then takes no further bytes.
- R10: All fields of A come before those of B. Offsets count from 0 at the first byte after the basic instruction. An operand whose use flag is low is ignored, whatever its mode.
- R11: A byte is taken only on a cycle with byte_valid and byte_ready both high. Gaps in byte_valid only delay the parse, and no byte is taken after the last field.
- R12: done is high for exactly one cycle, with ext_len equal to the number of bytes taken. Results hold until the next start. A start while busy is ignored, and a synchronous reset returns the block to idle with all results cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a parse (accepted when not busy) |
| use_a | input | 1 | Operand A exists |
| use_b | input | 1 | Operand B exists |
| mode_a | input | 5 | Addressing mode of operand A |
| mode_b | input | 5 | Addressing mode of operand B |
| sz_a | input | 2 | Size code of A (immediate length 1, 2, 4, 8) |
| sz_b | input | 2 | Size code of B |
| noimm_a | input | 1 | A is a destination or address operand |
| noimm_b | input | 1 | B is a destination or address operand |
| busy | output | 1 | A parse is in progress |
| byte_valid | input | 1 | byte_data holds the next instruction byte |
| byte_data | input | 8 | Next instruction byte |
| byte_ready | output | 1 | Block takes byte_data this cycle if valid |
| done | output | 1 | One-cycle completion pulse |
| ext_len | output | OFF_W | Total extension bytes taken |
| idx_off | output | 2 x OFF_W | Offset of the index byte; [0] is A, [1] is B |
| idx_reg | output | 2 x 3 | Index register from each index byte |
| fld_off | output | 4 x OFF_W | Field offsets: [0] A first, [1] A second, [2] B first, [3] B second |
| fld_cnt | output | 2 x 2 | Number of fields per operand |
| err_reserved | output | 1 | Reserved mode seen |
| err_imm | output | 1 | Immediate on an operand that may not be one |
| err_nested | output | 1 | Index byte names a scaled-index base |

## Verification
The hardest state to reach from the ports is an index byte whose own base mode selects further extension fields. It only occurs when the bytes streamed after an indexed mode carry a chosen 5-bit pattern in bits 7:3. The table therefore builds each index byte by hand: one with a register-relative base and one with an immediate base in the same instruction, one with a scaled base, and one on B alone. Displacement first bytes are picked to cover all three length encodings. Filler bytes that would read as valid 1-byte displacements follow every stream, so any over-read shows up as a wrong count. One run is repeated with gaps in byte_valid and a second start pulse while busy.

// File: rtl/ope_pkg.sv
package ope_pkg;

    localparam int OPE_NOPS  = 2;
    localparam int OPE_NFLD  = 2;
    localparam int OPE_MODEW = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_IDX,
        S_PLAN,
        S_HEAD,
        S_TAIL,
        S_DONE
    } ope_state_e;

    // What one operand still needs after any index byte has been resolved.
    typedef struct packed {
        logic [1:0] ndisp;
        logic       has_imm;
        logic [3:0] imm_len;
        logic       reserved;
        logic       imm_bad;
    } ope_plan_t;

    function automatic logic is_scaled(input logic [OPE_MODEW-1:0] m);
        return m[4:2] == 3'b111;
    endfunction

    function automatic logic [3:0] disp_len(input logic [7:0] b);
        if (!b[7])
            return 4'd1;
        else if (!b[6])
            return 4'd2;
        else
            return 4'd4;
    endfunction

    function automatic logic [3:0] imm_bytes(input logic [1:0] sz);
        return 4'd1 << sz;
    endfunction

    function automatic logic [1:0] field_total(input ope_plan_t p);
        return p.ndisp + {1'b0, p.has_imm};
    endfunction

endpackage

// File: rtl/ope_mode_decode.sv
module ope_mode_decode
    import ope_pkg::*;
(
    input  logic                 en,
    input  logic [OPE_MODEW-1:0] mode,
    input  logic [1:0]           size,
    input  logic                 no_imm,
    output ope_plan_t            plan
);

    always_comb begin
        plan = '0;
        if (en) begin
            if (mode[4:3] == 2'b00) begin
                plan = '0;
            end else if (mode[4:3] == 2'b01) begin
                plan.ndisp = 2'd1;
            end else begin
                case (mode)
                    5'h10, 5'h11, 5'h12, 5'h16: plan.ndisp = 2'd2;
                    5'h13:                      plan.reserved = 1'b1;
                    5'h14: begin
                        if (no_imm) begin
                            plan.imm_bad = 1'b1;
                        end else begin
                            plan.has_imm = 1'b1;
                            plan.imm_len = imm_bytes(size);
                        end
                    end
                    5'h15, 5'h18, 5'h19, 5'h1A, 5'h1B: plan.ndisp = 2'd1;
                    default:                    plan = '0;
                endcase
            end
        end
    end

    // An operand is either an immediate or a displacement user, never both.
    always_comb begin
        assert (!(plan.has_imm && (plan.ndisp != 2'd0)))
            else $error("p_imm_excl_r5: immediate combined with displacement");
    end

endmodule

// File: rtl/ope_index_split.sv
module ope_index_split
    import ope_pkg::*;
(
    input  logic [7:0]           ibyte,
    output logic [OPE_MODEW-1:0] eff_mode,
    output logic [2:0]           ireg,
    output logic                 nested
);

    logic [OPE_MODEW-1:0] base;

    always_comb begin
        base     = ibyte[7:3];
        ireg     = ibyte[2:0];
        nested   = is_scaled(base);
        // A scaled base is not followed further; it is treated as a bare register.
        eff_mode = nested ? '0 : base;
    end

endmodule

// File: rtl/ope_ext_parser.sv
module ope_ext_parser
    import ope_pkg::*;
#(
    parameter int OFF_W = 6
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                start,
    input  logic                                use_a,
    input  logic                                use_b,
    input  logic [4:0]                          mode_a,
    input  logic [4:0]                          mode_b,
    input  logic [1:0]                          sz_a,
    input  logic [1:0]                          sz_b,
    input  logic                                noimm_a,
    input  logic                                noimm_b,
    output logic                                busy,
    input  logic                                byte_valid,
    input  logic [7:0]                          byte_data,
    output logic                                byte_ready,
    output logic                                done,
    output logic [OFF_W-1:0]                    ext_len,
    output logic [1:0][OFF_W-1:0]               idx_off,
    output logic [1:0][2:0]                     idx_reg,
    output logic [3:0][OFF_W-1:0]               fld_off,
    output logic [1:0][1:0]                     fld_cnt,
    output logic                                err_reserved,
    output logic                                err_imm,
    output logic                                err_nested
);

    localparam int NSLOT = OPE_NOPS * OPE_NFLD;

    ope_state_e               state;
    logic                     op;
    logic                     fld;
    logic [OFF_W-1:0]         cnt;
    logic [2:0]               remain;
    logic [OPE_NOPS-1:0]      use_q;
    logic [OPE_NOPS-1:0]      noimm_q;
    logic [OPE_NOPS-1:0]      idxneed_q;
    logic [1:0]               size_q [OPE_NOPS];
    logic [OPE_MODEW-1:0]     eff_q  [OPE_NOPS];

    ope_plan_t                plans  [OPE_NOPS];
    logic [1:0]               nf     [OPE_NOPS];
    ope_plan_t                cur;
    logic [3:0]               head_len;
    logic                     hs;
    logic                     need_a;
    logic                     need_b;

    logic [OPE_MODEW-1:0]     spl_eff;
    logic [2:0]               spl_reg;
    logic                     spl_nested;

    logic                     nxt_op;
    logic                     nxt_fld;
    ope_state_e               nxt_state;

    genvar g;
    generate
        for (g = 0; g < OPE_NOPS; g++) begin : g_dec
            ope_mode_decode u_dec (
                .en     (use_q[g]),
                .mode   (eff_q[g]),
                .size   (size_q[g]),
                .no_imm (noimm_q[g]),
                .plan   (plans[g])
            );
            assign nf[g] = field_total(plans[g]);
        end
    endgenerate

    ope_index_split u_split (
        .ibyte    (byte_data),
        .eff_mode (spl_eff),
        .ireg     (spl_reg),
        .nested   (spl_nested)
    );

    assign busy       = (state != S_IDLE);
    assign byte_ready = (state == S_IDX) || (state == S_HEAD) || (state == S_TAIL);
    assign done       = (state == S_DONE);
    assign ext_len    = cnt;
    assign hs         = byte_valid && byte_ready;
    assign need_a     = use_a && is_scaled(mode_a);
    assign need_b     = use_b && is_scaled(mode_b);

    always_comb begin
        cur = plans[op];
        if ({1'b0, fld} < cur.ndisp)
            head_len = disp_len(byte_data);
        else
            head_len = cur.imm_len;
    end

    // Where to go after the current field finishes.
    always_comb begin
        nxt_op    = op;
        nxt_fld   = ~fld;
        nxt_state = S_HEAD;
        if (({1'b0, fld} + 2'd1) == nf[op]) begin
            if (!op && (nf[1] != 2'd0)) begin
                nxt_op  = 1'b1;
                nxt_fld = 1'b0;
            end else begin
                nxt_state = S_DONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= S_IDLE;
            op           <= 1'b0;
            fld          <= 1'b0;
            cnt          <= '0;
            remain       <= '0;
            use_q        <= '0;
            noimm_q      <= '0;
            idxneed_q    <= '0;
            for (int i = 0; i < OPE_NOPS; i++) begin
                size_q[i] <= '0;
                eff_q[i]  <= '0;
            end
            idx_off      <= '0;
            idx_reg      <= '0;
            fld_off      <= '0;
            fld_cnt      <= '0;
            err_reserved <= 1'b0;
            err_imm      <= 1'b0;
            err_nested   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        use_q        <= {use_b, use_a};
                        noimm_q      <= {noimm_b, noimm_a};
                        idxneed_q    <= {need_b, need_a};
                        size_q[0]    <= sz_a;
                        size_q[1]    <= sz_b;
                        eff_q[0]     <= mode_a;
                        eff_q[1]     <= mode_b;
                        cnt          <= '0;
                        fld          <= 1'b0;
                        idx_off      <= '0;
                        idx_reg      <= '0;
                        fld_off      <= '0;
                        fld_cnt      <= '0;
                        err_reserved <= 1'b0;
                        err_imm      <= 1'b0;
                        err_nested   <= 1'b0;
                        if (need_a) begin
                            op    <= 1'b0;
                            state <= S_IDX;
                        end else if (need_b) begin
                            op    <= 1'b1;
                            state <= S_IDX;
                        end else begin
                            state <= S_PLAN;
                        end
                    end
                end
                S_IDX: begin
                    if (hs) begin
                        idx_off[op] <= cnt;
                        idx_reg[op] <= spl_reg;
                        eff_q[op]   <= spl_eff;
                        if (spl_nested)
                            err_nested <= 1'b1;
                        cnt <= cnt + OFF_W'(1);
                        if (!op && idxneed_q[1])
                            op <= 1'b1;
                        else
                            state <= S_PLAN;
                    end
                end
                S_PLAN: begin
                    err_reserved <= plans[0].reserved | plans[1].reserved;
                    err_imm      <= plans[0].imm_bad | plans[1].imm_bad;
                    fld_cnt[0]   <= nf[0];
                    fld_cnt[1]   <= nf[1];
                    fld          <= 1'b0;
                    if (nf[0] != 2'd0) begin
                        op    <= 1'b0;
                        state <= S_HEAD;
                    end else if (nf[1] != 2'd0) begin
                        op    <= 1'b1;
                        state <= S_HEAD;
                    end else begin
                        state <= S_DONE;
                    end
                end
                S_HEAD: begin
                    if (hs) begin
                        fld_off[{op, fld}] <= cnt;
                        cnt <= cnt + OFF_W'(1);
                        if (head_len == 4'd1) begin
                            op    <= nxt_op;
                            fld   <= nxt_fld;
                            state <= nxt_state;
                        end else begin
                            remain <= 3'(head_len - 4'd1);
                            state  <= S_TAIL;
                        end
                    end
                end
                S_TAIL: begin
                    if (hs) begin
                        cnt    <= cnt + OFF_W'(1);
                        remain <= remain - 3'd1;
                        if (remain == 3'd1) begin
                            op    <= nxt_op;
                            fld   <= nxt_fld;
                            state <= nxt_state;
                        end
                    end
                end
                S_DONE: begin
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    p_ready_busy_r11: assert property (@(posedge clk) disable iff (rst)
        byte_ready |-> busy)
        else $error("p_ready_busy_r11");

    p_len_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && !(byte_valid && byte_ready)) |=> $stable(ext_len))
        else $error("p_len_hold_r11");

    p_len_step_r11: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && byte_ready) |=> (ext_len == $past(ext_len) + OFF_W'(1)))
        else $error("p_len_step_r11");

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done)
        else $error("p_done_pulse_r12");

    p_start_busy_r12: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy)
        else $error("p_start_busy_r12");

    p_tail_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        (state == S_TAIL) |-> (remain != 3'd0))
        else $error("p_tail_nonzero_r4");

    p_flat_base_r9: assert property (@(posedge clk) disable iff (rst)
        (state == S_PLAN) |-> (!is_scaled(eff_q[0]) || !use_q[0]) && (!is_scaled(eff_q[1]) || !use_q[1]))
        else $error("p_flat_base_r9");

    p_no_read_reserved_r7: assert property (@(posedge clk) disable iff (rst)
        (state == S_HEAD) |-> !cur.reserved && !cur.imm_bad)
        else $error("p_no_read_reserved_r7");

    p_slots_fit_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (fld_cnt[0] <= 2'(OPE_NFLD)) && (fld_cnt[1] <= 2'(OPE_NFLD)) && (NSLOT == 4))
        else $error("p_slots_fit_r3");

endmodule

// File: tb/tb_ope_ext_parser.sv
`timescale 1ns/1ps
module tb_ope_ext_parser;

    localparam int OFF_W = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic use_a = 1'b0, use_b = 1'b0;
    logic [4:0] mode_a = '0, mode_b = '0;
    logic [1:0] sz_a = '0, sz_b = '0;
    logic noimm_a = 1'b0, noimm_b = 1'b0;
    logic busy;
    logic byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic byte_ready;
    logic done;
    logic [OFF_W-1:0] ext_len;
    logic [1:0][OFF_W-1:0] idx_off;
    logic [1:0][2:0] idx_reg;
    logic [3:0][OFF_W-1:0] fld_off;
    logic [1:0][1:0] fld_cnt;
    logic err_reserved, err_imm, err_nested;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    ope_ext_parser #(.OFF_W(OFF_W)) dut (
        .clk(clk), .rst(rst), .start(start),
        .use_a(use_a), .use_b(use_b),
        .mode_a(mode_a), .mode_b(mode_b),
        .sz_a(sz_a), .sz_b(sz_b),
        .noimm_a(noimm_a), .noimm_b(noimm_b),
        .busy(busy),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
        .done(done), .ext_len(ext_len),
        .idx_off(idx_off), .idx_reg(idx_reg),
        .fld_off(fld_off), .fld_cnt(fld_cnt),
        .err_reserved(err_reserved), .err_imm(err_imm), .err_nested(err_nested)
    );

    typedef struct packed {
        logic [4:0]  ma;
        logic [4:0]  mb;
        logic [1:0]  sa;
        logic [1:0]  sb;
        logic [1:0]  ni;   // [0] A, [1] B
        logic [1:0]  us;   // [0] A, [1] B
        logic [3:0]  nb;
        logic [95:0] by;   // first byte in [95:88]
        logic [5:0]  len;
        logic [2:0]  err;  // {nested, imm, reserved}
        logic [5:0]  ao0;
        logic [5:0]  ao1;
        logic [5:0]  bo0;
        logic [5:0]  bo1;
        logic [1:0]  ac;
        logic [1:0]  bc;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        '{5'h03, 5'h05, 2'd0, 2'd0, 2'b00, 2'b11, 4'd0,
          96'h00_00_00_00_00_00_00_00_00_00_00_00, 6'd0, 3'b000, 6'd0, 6'd0, 6'd0, 6'd0, 2'd0, 2'd0},
        '{5'h09, 5'h17, 2'd0, 2'd0, 2'b00, 2'b11, 4'd1,
          96'h05_00_00_00_00_00_00_00_00_00_00_00, 6'd1, 3'b000, 6'd0, 6'd0, 6'd0, 6'd0, 2'd1, 2'd0},
        '{5'h10, 5'h18, 2'd0, 2'd0, 2'b00, 2'b11, 4'd7,
          96'h81_00_7F_C0_00_00_00_00_00_00_00_00, 6'd7, 3'b000, 6'd0, 6'd2, 6'd3, 6'd0, 2'd2, 2'd1},
        '{5'h14, 5'h1B, 2'd2, 2'd0, 2'b00, 2'b11, 4'd5,
          96'hC0_FF_80_00_40_00_00_00_00_00_00_00, 6'd5, 3'b000, 6'd0, 6'd0, 6'd4, 6'd0, 2'd1, 2'd1},
        '{5'h1C, 5'h1F, 2'd0, 2'd0, 2'b00, 2'b11, 4'd5,
          96'h43_A6_90_00_EE_00_00_00_00_00_00_00, 6'd5, 3'b000, 6'd2, 6'd0, 6'd4, 6'd0, 2'd1, 2'd1},
        '{5'h13, 5'h15, 2'd0, 2'd0, 2'b00, 2'b11, 4'd4,
          96'hC1_01_02_03_00_00_00_00_00_00_00_00, 6'd4, 3'b001, 6'd0, 6'd0, 6'd0, 6'd0, 2'd0, 2'd1},
        '{5'h0A, 5'h14, 2'd0, 2'd3, 2'b10, 2'b11, 4'd1,
          96'h3F_00_00_00_00_00_00_00_00_00_00_00, 6'd1, 3'b010, 6'd0, 6'd0, 6'd0, 6'd0, 2'd1, 2'd0},
        '{5'h1D, 5'h16, 2'd0, 2'd0, 2'b00, 2'b11, 4'd4,
          96'hF1_01_80_05_00_00_00_00_00_00_00_00, 6'd4, 3'b100, 6'd0, 6'd0, 6'd1, 6'd2, 2'd0, 2'd2},
        '{5'h14, 5'h00, 2'd3, 2'd0, 2'b00, 2'b01, 4'd8,
          96'h11_22_33_44_55_66_77_88_00_00_00_00, 6'd8, 3'b000, 6'd0, 6'd0, 6'd0, 6'd0, 2'd1, 2'd0},
        '{5'h12, 5'h19, 2'd0, 2'd0, 2'b00, 2'b11, 4'd10,
          96'hFF_00_00_00_C0_01_02_03_BF_11_00_00, 6'd10, 3'b000, 6'd0, 6'd4, 6'd8, 6'd0, 2'd2, 2'd1},
        '{5'h1C, 5'h1A, 2'd0, 2'd0, 2'b00, 2'b10, 4'd1,
          96'h22_00_00_00_00_00_00_00_00_00_00_00, 6'd1, 3'b000, 6'd0, 6'd0, 6'd0, 6'd0, 2'd0, 2'd1},
        '{5'h02, 5'h1E, 2'd0, 2'd0, 2'b00, 2'b11, 4'd2,
          96'h67_01_00_00_00_00_00_00_00_00_00_00, 6'd2, 3'b000, 6'd0, 6'd0, 6'd1, 6'd0, 2'd0, 2'd1}
    };

    function automatic string tag_of(input int k);
        case (k)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R5";
            4: return "R8";
            5: return "R7";
            6: return "R6";
            7: return "R9";
            8: return "R5";
            9: return "R4";
            10: return "R10";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    task automatic drive_modes(input vec_t v);
        mode_a  = v.ma;    mode_b  = v.mb;
        sz_a    = v.sa;    sz_b    = v.sb;
        noimm_a = v.ni[0]; noimm_b = v.ni[1];
        use_a   = v.us[0]; use_b   = v.us[1];
    endtask

    task automatic run_vec(input int k, input bit bub, input bit poke);
        vec_t v;
        int idx;
        bit pend;
        bit seen;
        string t;
        v = VT[k];
        t = tag_of(k);
        @(negedge clk);
        drive_modes(v);
        start = 1'b1;
        idx = 0;
        pend = 1'b0;
        seen = 1'b0;
        for (int cyc = 0; cyc < 200; cyc++) begin
            @(negedge clk);
            start = (poke && cyc == 1);
            if (poke && cyc == 1) mode_a = 5'h14;
            if (pend) idx++;
            if (done) begin
                seen = 1'b1;
                break;
            end
            byte_valid = bub ? cyc[0] : 1'b1;
            byte_data  = (idx < int'(v.nb)) ? v.by[95 - 8*idx -: 8] : 8'h00;
            pend = byte_valid && byte_ready;
        end
        byte_valid = 1'b0;
        start = 1'b0;
        chk("R12", "done seen", int'(seen), 1);
        chk(t, "ext_len", int'(ext_len), int'(v.len));
        chk("R11", "bytes taken", idx, int'(v.nb));
        chk(t, "error flags", int'({err_nested, err_imm, err_reserved}), int'(v.err));
        chk("R10", "A field0 offset", int'(fld_off[0]), int'(v.ao0));
        chk("R10", "A field1 offset", int'(fld_off[1]), int'(v.ao1));
        chk("R10", "B field0 offset", int'(fld_off[2]), int'(v.bo0));
        chk("R10", "B field1 offset", int'(fld_off[3]), int'(v.bo1));
        chk(t, "A field count", int'(fld_cnt[0]), int'(v.ac));
        chk(t, "B field count", int'(fld_cnt[1]), int'(v.bc));
        @(negedge clk);
        chk("R12", "done width", int'(done), 0);
        chk("R12", "ext_len held", int'(ext_len), int'(v.len));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R12 watchdog expired: actual 1 expected 0");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // Reset state (R12)
        chk("R12", "reset busy", int'(busy), 0);
        chk("R12", "reset done", int'(done), 0);
        chk("R12", "reset ready", int'(byte_ready), 0);
        chk("R12", "reset ext_len", int'(ext_len), 0);
        rst = 1'b0;

        // Table walk
        for (int k = 0; k < NV; k++) begin
            run_vec(k, 1'b0, 1'b0);
            if (k == 4) begin
                chk("R8", "A index offset", int'(idx_off[0]), 0);
                chk("R8", "B index offset", int'(idx_off[1]), 1);
                chk("R8", "A index reg", int'(idx_reg[0]), 3);
                chk("R8", "B index reg", int'(idx_reg[1]), 6);
            end
            if (k == 7) begin
                chk("R9", "A index reg", int'(idx_reg[0]), 1);
                chk("R9", "A index offset", int'(idx_off[0]), 0);
            end
            if (k == 11) begin
                chk("R8", "B-only index offset", int'(idx_off[1]), 0);
                chk("R8", "B-only index reg", int'(idx_reg[1]), 7);
            end
        end

        // Stalls in byte_valid plus a start while busy (R11, R12)
        run_vec(2, 1'b1, 1'b1);
        run_vec(9, 1'b1, 1'b0);

        // Synchronous reset in the middle of a parse (R12)
        @(negedge clk);
        drive_modes(VT[9]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        byte_valid = 1'b1;
        byte_data = 8'hFF;
        repeat (3) @(negedge clk);
        byte_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk("R12", "mid reset busy", int'(busy), 0);
        chk("R12", "mid reset ext_len", int'(ext_len), 0);
        chk("R12", "mid reset field count", int'(fld_cnt[0]), 0);
        chk("R12", "mid reset ready", int'(byte_ready), 0);
        rst = 1'b0;
        run_vec(1, 1'b0, 1'b0);

        summary();
        $finish;
    end

endmodule